// File: doc/BRIEF.md
# Debug Mailbox Handshake Controller

This block is a two-way mailbox between a debug handler running on the processor and an external debugger. The debugger places 32-bit words into a receive register, and the processor collects them. The processor places 32-bit words into a transmit register, and the debugger collects them. Each direction has its own ready flag and its own small state machine, so the two transfer directions are synchronized independently.

The processor reaches the block through a plain synchronous register port with three words: a status word, the receive data and the transmit data. The debugger side is a set of parallel strobes with data. These strobes stand in for the scan-chain data registers; the scan logic itself is not part of the block.

The status word keeps its four flags in the top nibble. A single register move can therefore load them straight into the processor's N, Z, C and V condition flags, and the next instruction can be conditional on them. The flags are:
- a sticky overflow flag, raised when the debugger writes over receive data that has not been read yet;
- a download branch flag, which the debugger supplies together with each accepted receive word.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, the status word, the receive data, the transmit data and both debugger-side full outputs are all zero.
- R2: Processor addresses are 0 for status, 1 for receive data, 2 for transmit data; address 3 reads as zero. In the status word, bit 31 is receive-full, bit 30 is overflow, bit 29 is the download flag and bit 28 is transmit-full. Bits 27 to 0 always read as zero.
- R3: A debugger receive write while the receive channel is empty stores the data and the download-flag input, and sets receive-full (status bit 31 and `dbg_rx_full`) from the next cycle on.
- R4: A processor read of address 1 returns the stored receive word and clears receive-full from the next cycle on. The download flag keeps its value.
- R5: A debugger receive write while receive-full is set and no processor receive read happens in the same cycle sets the overflow flag. The new data and its download flag are discarded, and the earlier word is kept.
- R6: The overflow flag is sticky. Only a processor write to status bit 30 changes it, and that write loads the value of the bit. If an overflow event and a processor write of 0 fall in the same cycle, the flag ends up set.
- R7: Processor writes to status bits 31, 29, 28 and 27 to 0 have no effect.
- R8: If a processor receive read and a debugger receive write fall in the same cycle, the read returns the old word, the new word is stored, receive-full stays set, and no overflow is flagged.
- R9: A processor write to address 2 stores the transmit word and sets transmit-full (status bit 28 and `dbg_tx_full`). `dbg_tx_data` shows the stored word, and address 2 reads it back.
- R10: A debugger transmit read clears transmit-full. If it falls in the same cycle as a processor transmit write, the debugger sees the old word, the new word is stored, and transmit-full stays set.
- R11: A processor transmit write while transmit-full is set replaces the word, and transmit-full stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Processor access strobe |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 2 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, valid in the cycle of the read |
| dbg_rx_wr | input | 1 | Debugger writes the receive register |
| dbg_rx_data | input | 32 | Debugger receive data |
| dbg_rx_dl | input | 1 | Download flag sent with the receive word |
| dbg_rx_full | output | 1 | Receive word is waiting for the processor |
| dbg_tx_rd | input | 1 | Debugger collects the transmit word |
| dbg_tx_data | output | 32 | Current transmit word |
| dbg_tx_full | output | 1 | Fresh transmit word is present |

States and transitions:
- Receive channel:
  - RX_EMPTY goes to RX_FULL on a debugger write.
  - RX_FULL goes to RX_EMPTY on a processor read without a debugger write.
  - RX_FULL stays in RX_FULL on a write without a read (overflow) and on a write together with a read (reload).
- Transmit channel:
  - TX_IDLE goes to TX_LOADED on a processor write.
  - TX_LOADED goes to TX_IDLE on a debugger read without a processor write.
  - TX_LOADED stays in TX_LOADED on a write, with or without a read.

## Verification
The hardest situations to reach are the same-cycle collisions:
- a processor receive read meeting a debugger receive write;
- a processor transmit write meeting a debugger transmit read;
- an overflow event meeting a software clear of the overflow bit.

The bench reaches them with one cycle task that drives the processor port and both debugger strobes in the same half-cycle. It first fills the channel with an ordinary write, then issues the colliding pair. After that it reads back the stored words and the status word to see which side won.

// File: rtl/dbg_mailbox_pkg.sv
package dbg_mailbox_pkg;

    localparam int MB_ADDR_W = 2;

    localparam logic [MB_ADDR_W-1:0] ADR_STATUS = 2'd0;
    localparam logic [MB_ADDR_W-1:0] ADR_RXDATA = 2'd1;
    localparam logic [MB_ADDR_W-1:0] ADR_TXDATA = 2'd2;

    typedef enum logic {
        RX_EMPTY,
        RX_FULL
    } rx_state_e;

    typedef enum logic {
        TX_IDLE,
        TX_LOADED
    } tx_state_e;

endpackage

// File: rtl/dbg_mb_rx_chan.sv
// Receive direction: debugger writes, processor reads.
module dbg_mb_rx_chan
    import dbg_mailbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              dl_i,
    input  logic              rd_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o,
    output logic              dl_o,
    output logic              ovf_evt_o
);

    rx_state_e         state_q, state_d;
    logic              load;
    logic [DATA_W-1:0] data_q;
    logic              dl_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (wr_i)          state_d = RX_FULL;
            RX_FULL:  if (rd_i && !wr_i) state_d = RX_EMPTY;
            default:                     state_d = RX_EMPTY;
        endcase
    end

    // Outputs per state
    always_comb begin
        load      = 1'b0;
        full_o    = 1'b0;
        ovf_evt_o = 1'b0;
        unique case (state_q)
            RX_EMPTY: begin
                load = wr_i;
            end
            RX_FULL: begin
                full_o    = 1'b1;
                load      = wr_i && rd_i;
                ovf_evt_o = wr_i && !rd_i;
            end
            default: begin
                load = 1'b0;
            end
        endcase
    end

    // Data and download flag, loaded only on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dl_q   <= 1'b0;
        end else if (load) begin
            data_q <= wdata_i;
            dl_q   <= dl_i;
        end
    end

    assign data_o = data_q;
    assign dl_o   = dl_q;

endmodule

// File: rtl/dbg_mb_tx_chan.sv
// Transmit direction: processor writes, debugger reads.
module dbg_mb_tx_chan
    import dbg_mailbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rd_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (wr_i)          state_d = TX_LOADED;
            TX_LOADED: if (rd_i && !wr_i) state_d = TX_IDLE;
            default:                      state_d = TX_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        unique case (state_q)
            TX_IDLE:   full_o = 1'b0;
            TX_LOADED: full_o = 1'b1;
            default:   full_o = 1'b0;
        endcase
    end

    // A processor write always replaces the word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_i) begin
            data_q <= wdata_i;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/dbg_mb_regs.sv
// Sticky overflow flag and the processor read multiplexer.
module dbg_mb_regs
    import dbg_mailbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stat_wr_i,
    input  logic                 ovf_wbit_i,
    input  logic                 ovf_evt_i,
    input  logic                 rd_en_i,
    input  logic [MB_ADDR_W-1:0] addr_i,
    input  logic                 rx_full_i,
    input  logic                 rx_dl_i,
    input  logic                 tx_full_i,
    input  logic [DATA_W-1:0]    rx_data_i,
    input  logic [DATA_W-1:0]    tx_data_i,
    output logic                 ovf_o,
    output logic [DATA_W-1:0]    rdata_o
);

    localparam int FLAG_N = 4;
    localparam int ZERO_W = DATA_W - FLAG_N;

    logic              ovf_q;
    logic [DATA_W-1:0] status_word;

    // An overflow event outranks a software write of the bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (ovf_evt_i) begin
            ovf_q <= 1'b1;
        end else if (stat_wr_i) begin
            ovf_q <= ovf_wbit_i;
        end
    end

    assign status_word = {rx_full_i, ovf_q, rx_dl_i, tx_full_i, {ZERO_W{1'b0}}};

    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                ADR_STATUS: rdata_o = status_word;
                ADR_RXDATA: rdata_o = rx_data_i;
                ADR_TXDATA: rdata_o = tx_data_i;
                default:    rdata_o = '0;
            endcase
        end
    end

    assign ovf_o = ovf_q;

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mailbox_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_sel,
    input  logic                 cpu_we,
    input  logic [MB_ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    input  logic                 dbg_rx_wr,
    input  logic [DATA_W-1:0]    dbg_rx_data,
    input  logic                 dbg_rx_dl,
    output logic                 dbg_rx_full,
    input  logic                 dbg_tx_rd,
    output logic [DATA_W-1:0]    dbg_tx_data,
    output logic                 dbg_tx_full
);

    localparam int OVF_BIT = DATA_W - 2;

    logic              cpu_rd, cpu_wr;
    logic              rx_rd, tx_wr, stat_wr;
    logic              ovf_evt, st_ovf, st_dl;
    logic [DATA_W-1:0] rx_data;

    assign cpu_rd  = cpu_sel && !cpu_we;
    assign cpu_wr  = cpu_sel && cpu_we;
    assign rx_rd   = cpu_rd && (cpu_addr == ADR_RXDATA);
    assign tx_wr   = cpu_wr && (cpu_addr == ADR_TXDATA);
    assign stat_wr = cpu_wr && (cpu_addr == ADR_STATUS);

    dbg_mb_rx_chan #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (dbg_rx_wr),
        .wdata_i   (dbg_rx_data),
        .dl_i      (dbg_rx_dl),
        .rd_i      (rx_rd),
        .full_o    (dbg_rx_full),
        .data_o    (rx_data),
        .dl_o      (st_dl),
        .ovf_evt_o (ovf_evt)
    );

    dbg_mb_tx_chan #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (tx_wr),
        .wdata_i (cpu_wdata),
        .rd_i    (dbg_tx_rd),
        .full_o  (dbg_tx_full),
        .data_o  (dbg_tx_data)
    );

    dbg_mb_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_wr_i  (stat_wr),
        .ovf_wbit_i (cpu_wdata[OVF_BIT]),
        .ovf_evt_i  (ovf_evt),
        .rd_en_i    (cpu_rd),
        .addr_i     (cpu_addr),
        .rx_full_i  (dbg_rx_full),
        .rx_dl_i    (st_dl),
        .tx_full_i  (dbg_tx_full),
        .rx_data_i  (rx_data),
        .tx_data_i  (dbg_tx_data),
        .ovf_o      (st_ovf),
        .rdata_o    (cpu_rdata)
    );

endmodule

// File: rtl/dbg_mailbox_chk.sv
module dbg_mailbox_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_we,
    input logic [1:0]        cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              dbg_rx_wr,
    input logic              dbg_tx_rd,
    input logic              dbg_rx_full,
    input logic              dbg_tx_full,
    input logic              st_ovf,
    input logic              st_dl,
    input logic [DATA_W-1:0] rx_data
);

    logic rx_rd_c, tx_wr_c, st_wr_c, st_rd_c;

    assign rx_rd_c = cpu_sel && !cpu_we && (cpu_addr == 2'd1);
    assign tx_wr_c = cpu_sel && cpu_we && (cpu_addr == 2'd2);
    assign st_wr_c = cpu_sel && cpu_we && (cpu_addr == 2'd0);
    assign st_rd_c = cpu_sel && !cpu_we && (cpu_addr == 2'd0);

    a_r2_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd_c |-> cpu_rdata[DATA_W-5:0] == '0);

    a_r2_addr3_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_we && cpu_addr == 2'd3) |-> cpu_rdata == '0);

    a_r3_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rx_wr |=> dbg_rx_full);

    a_r4_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_c && !dbg_rx_wr) |=> !dbg_rx_full);

    a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rx_full && dbg_rx_wr && !rx_rd_c) |=> st_ovf);

    a_r5_keep_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rx_full && dbg_rx_wr && !rx_rd_c) |=> ($stable(rx_data) && $stable(st_dl)));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovf && !(st_wr_c && !cpu_wdata[DATA_W-2])) |=> st_ovf);

    a_r6_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_ovf && !st_wr_c && !(dbg_rx_full && dbg_rx_wr)) |=> !st_ovf);

    a_r7_ro_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_c && !dbg_rx_wr && !dbg_tx_rd)
        |=> ($stable(dbg_rx_full) && $stable(st_dl) && $stable(dbg_tx_full)));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_c && dbg_rx_wr && !st_ovf) |=> (!st_ovf && dbg_rx_full));

    a_r9_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_c |=> dbg_tx_full);

    a_r10_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_tx_rd && !tx_wr_c) |=> !dbg_tx_full);

endmodule

bind dbg_mailbox dbg_mailbox_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_dbg_mailbox.sv
module test_dbg_mailbox;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic        dbg_rx_wr = 1'b0, dbg_rx_dl = 1'b0, dbg_rx_full;
    logic [31:0] dbg_rx_data = '0, dbg_tx_data;
    logic        dbg_tx_rd = 1'b0, dbg_tx_full;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    dbg_mailbox i_dbg_mailbox (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_sel     (cpu_sel),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .cpu_rdata   (cpu_rdata),
        .dbg_rx_wr   (dbg_rx_wr),
        .dbg_rx_data (dbg_rx_data),
        .dbg_rx_dl   (dbg_rx_dl),
        .dbg_rx_full (dbg_rx_full),
        .dbg_tx_rd   (dbg_tx_rd),
        .dbg_tx_data (dbg_tx_data),
        .dbg_tx_full (dbg_tx_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock cycle with every strobe driven together
    task automatic cyc(input bit sel, input bit we, input logic [1:0] addr,
                       input logic [31:0] wd, input bit rxw, input logic [31:0] rxd,
                       input bit dl, input bit txr,
                       output logic [31:0] rd, output logic [31:0] txd);
        @(negedge clk);
        cpu_sel = sel; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        dbg_rx_wr = rxw; dbg_rx_data = rxd; dbg_rx_dl = dl; dbg_tx_rd = txr;
        #2;
        rd  = cpu_rdata;
        txd = dbg_tx_data;
        @(posedge clk);
        #1;
        cpu_sel = 1'b0; cpu_we = 1'b0; dbg_rx_wr = 1'b0; dbg_tx_rd = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] addr, output logic [31:0] rd);
        logic [31:0] t;
        cyc(1, 0, addr, '0, 0, '0, 0, 0, rd, t);
    endtask

    task automatic cpu_write(input logic [1:0] addr, input logic [31:0] wd);
        logic [31:0] r, t;
        cyc(1, 1, addr, wd, 0, '0, 0, 0, r, t);
    endtask

    task automatic dbg_write(input logic [31:0] d, input bit dl);
        logic [31:0] r, t;
        cyc(0, 0, 2'd0, '0, 1, d, dl, 0, r, t);
    endtask

    task automatic dbg_read(output logic [31:0] txd);
        logic [31:0] r;
        cyc(0, 0, 2'd0, '0, 0, '0, 0, 1, r, txd);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 rx_full", {31'd0, dbg_rx_full}, 32'd0);
        chk("R1 tx_full", {31'd0, dbg_tx_full}, 32'd0);
        cpu_read(2'd0, v); chk("R1 status", v, 32'h0);
        cpu_read(2'd1, v); chk("R1 rx data", v, 32'h0);
        cpu_read(2'd2, v); chk("R1 tx data", v, 32'h0);
        cpu_read(2'd3, v); chk("R2 addr3 zero", v, 32'h0);
    endtask

    task automatic t_rx_basic;
        logic [31:0] v;
        dbg_write(32'hA5A5_0001, 1);
        chk("R3 rx_full port", {31'd0, dbg_rx_full}, 32'd1);
        cpu_read(2'd0, v); chk("R3 status full+dl", v, 32'hA000_0000);
        cpu_read(2'd1, v); chk("R4 rx data", v, 32'hA5A5_0001);
        cpu_read(2'd0, v); chk("R4 status after read", v, 32'h2000_0000);
        dbg_write(32'h0000_1234, 0);
        cpu_read(2'd1, v); chk("R4 rx data 2", v, 32'h0000_1234);
        cpu_read(2'd0, v); chk("R2 status empty", v, 32'h0);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        dbg_write(32'hD1D1_D1D1, 0);
        dbg_write(32'hD2D2_D2D2, 1);
        cpu_read(2'd0, v); chk("R5 status ovf, dl kept", v, 32'hC000_0000);
        cpu_read(2'd1, v); chk("R5 old data kept", v, 32'hD1D1_D1D1);
        cpu_read(2'd0, v); chk("R6 ovf sticky after read", v, 32'h4000_0000);
        dbg_write(32'h0000_0055, 0);
        cpu_read(2'd1, v);
        cpu_read(2'd0, v); chk("R6 ovf still sticky", v, 32'h4000_0000);
    endtask

    task automatic t_ovf_sw;
        logic [31:0] v, t;
        cpu_write(2'd0, 32'h0);
        cpu_read(2'd0, v); chk("R6 ovf cleared", v, 32'h0);
        cpu_write(2'd0, 32'h4000_0000);
        cpu_read(2'd0, v); chk("R6 ovf set by cpu", v, 32'h4000_0000);
        cpu_write(2'd0, 32'h0);
        dbg_write(32'hD3D3_0003, 0);
        cyc(1, 1, 2'd0, 32'h0, 1, 32'hD4D4_0004, 1, 0, v, t);
        cpu_read(2'd0, v); chk("R6 event beats clear", v, 32'hC000_0000);
        cpu_read(2'd1, v); chk("R5 data after clash", v, 32'hD3D3_0003);
        cpu_write(2'd0, 32'h0);
    endtask

    task automatic t_ro_bits;
        logic [31:0] v;
        cpu_write(2'd0, 32'hBFFF_FFFF);
        cpu_read(2'd0, v); chk("R7 ro bits ignored empty", v, 32'h0);
        dbg_write(32'h0000_00E5, 1);
        cpu_write(2'd0, 32'h0);
        cpu_read(2'd0, v); chk("R7 ro bits ignored full", v, 32'hA000_0000);
        chk("R7 rx_full port", {31'd0, dbg_rx_full}, 32'd1);
        cpu_read(2'd1, v);
    endtask

    task automatic t_collision_rx;
        logic [31:0] v, t;
        dbg_write(32'hE1E1_E1E1, 1);
        cyc(1, 0, 2'd1, '0, 1, 32'hE2E2_E2E2, 0, 0, v, t);
        chk("R8 read returns old", v, 32'hE1E1_E1E1);
        cpu_read(2'd0, v); chk("R8 full, no ovf", v, 32'h8000_0000);
        cpu_read(2'd1, v); chk("R8 new data stored", v, 32'hE2E2_E2E2);
        cpu_read(2'd0, v); chk("R8 status empty", v, 32'h0);
    endtask

    task automatic t_tx;
        logic [31:0] v, t;
        cpu_write(2'd2, 32'h7001_0001);
        chk("R9 tx_full port", {31'd0, dbg_tx_full}, 32'd1);
        cpu_read(2'd0, v); chk("R9 status tx bit", v, 32'h1000_0000);
        cpu_read(2'd2, v); chk("R9 tx readback", v, 32'h7001_0001);
        dbg_read(t); chk("R9 dbg tx data", t, 32'h7001_0001);
        cpu_read(2'd0, v); chk("R10 tx cleared", v, 32'h0);
        chk("R10 tx_full port", {31'd0, dbg_tx_full}, 32'd0);
        cpu_write(2'd2, 32'h7002_0002);
        cpu_write(2'd2, 32'h7003_0003);
        cpu_read(2'd0, v); chk("R11 still full", v, 32'h1000_0000);
        dbg_read(t); chk("R11 overwritten", t, 32'h7003_0003);
        cpu_write(2'd2, 32'h7004_0004);
        cyc(1, 1, 2'd2, 32'h7005_0005, 0, '0, 0, 1, v, t);
        chk("R10 collision old word", t, 32'h7004_0004);
        cpu_read(2'd0, v); chk("R10 collision stays full", v, 32'h1000_0000);
        dbg_read(t); chk("R10 collision new word", t, 32'h7005_0005);
        cpu_read(2'd0, v); chk("R10 final empty", v, 32'h0);
    endtask

    initial begin
        #(8 * 20000);
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_rx_basic;
        t_overflow;
        t_ovf_sw;
        t_ro_bits;
        t_collision_rx;
        t_tx;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule